// File: doc/BRIEF.md
# Packed Integer-to-Double Converter Unit

This execution unit takes a 64-bit operand that carries two signed 32-bit integers and returns a 128-bit result that carries two IEEE-754 double-precision values. Every 32-bit integer fits exactly in a double, so no rounding takes place and no arithmetic flags are raised. Each lane finds the leading one of the magnitude with a priority encoder, turns that position into the biased exponent and left-justifies the remaining bits into the fraction.

A source-kind input says whether the operand was read from a legacy packed-integer register or from memory. A register-sourced operation also resets a small model of the legacy floating-point stack state: the stack-top pointer goes to 0 and every tag entry becomes the all-zeros "valid" code. If a legacy floating-point exception is pending when a register-sourced operation arrives, the unit produces no numeric result and changes no state. It returns a beat flagged as "take the exception first". A memory-sourced operation ignores the pending exception and leaves the stack state alone. The floating-point unit elsewhere in the core keeps the stack state current through a plain load port.

Operands enter through a valid/ready input stream and results leave through a valid/ready output stream, with one register stage between them. An operand is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in that same cycle, so back-pressure on `out_ready` propagates to the input in the same cycle. While `out_valid` is high and `out_ready` is low, the output beat holds steady. Reset is synchronous and active high.

Top module: `pkcvt_unit`

## Requirements
- R1: Input bits 31:0 convert into result bits 63:0 and input bits 63:32 convert into result bits 127:64. Each lane is the exact double value of its signed integer, encoded with the sign in bit 63, an 11-bit exponent biased by 1023 in bits 62:52, and a 52-bit fraction in bits 51:0.
- R2: A zero integer produces an all-zeros 64-bit lane (+0.0), and no lane result ever has a zero exponent field together with a non-zero sign or fraction.
- R3: A negative integer sets the lane sign bit and encodes the magnitude. The value -2^31 gives 64'hC1E0_0000_0000_0000.
- R4: An accepted operand appears on the output with `out_valid` high directly after the accepting clock edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_result` and `out_exc` do not change.
- R5: An accepted operand with `in_from_reg`=1 and `fp_exc_pending`=0 sets `stk_top` to 0 and `tag_word` to all zeros after the accepting edge.
- R6: An accepted operand with `in_from_reg`=0 leaves `stk_top` and `tag_word` unchanged and returns `out_exc`=0 with the converted result, whatever the value of `fp_exc_pending`.
- R7: An accepted operand with `in_from_reg`=1 and `fp_exc_pending`=1 returns a beat with `out_exc`=1 and `out_result` all zeros, and leaves `stk_top` and `tag_word` unchanged.
- R8: After reset, `out_valid`=0, `in_ready`=1, `stk_top`=0 and `tag_word` is all ones (every entry has the 2'b11 "empty" code).
- R9: `st_wr_en`=1 loads `st_wr_top` and `st_wr_tag` into the stack state at the next edge. A register-sourced operation without a pending exception that is accepted on the same edge takes priority and clears the state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand valid |
| in_ready | output | 1 | Unit can accept an operand |
| in_src | input | 64 | Two packed signed 32-bit integers |
| in_from_reg | input | 1 | 1: operand from a legacy packed-integer register; 0: from memory |
| fp_exc_pending | input | 1 | A legacy floating-point exception is pending |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Consumer accepts the result beat |
| out_result | output | 128 | Two packed doubles (zero when out_exc is 1) |
| out_exc | output | 1 | Pending exception must be taken before this operation |
| st_wr_en | input | 1 | Load the stack state |
| st_wr_top | input | 3 | Stack-top value to load |
| st_wr_tag | input | 16 | Tag word to load, 2 bits per entry |
| stk_top | output | 3 | Current stack-top pointer |
| tag_word | output | 16 | Current tag word |

## Verification
A fault in the lane datapath, such as a wrong leading-one position or a bad fraction shift, shows as a wrong exponent or fraction on `out_result` in the first cycle after the operand is accepted. The sweep therefore covers every leading-one position, both signs, the range around zero and pseudo-random values. A fault in the stack-state model shows on `stk_top` or `tag_word` one cycle after the accepting edge. The bench preloads a distinctive state through the load port so that a clear which should not happen, or a missed clear, is visible for each source kind and for the pending-exception case. A handshake fault shows as a lost, duplicated or changing beat while `out_ready` is held low.

// File: rtl/pkcvt_pkg.sv
package pkcvt_pkg;
  localparam int DBL_W    = 64;
  localparam int EXP_W    = 11;
  localparam int FRAC_W   = 52;
  localparam int EXP_BIAS = 1023;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
  } dbl_t;
endpackage

// File: rtl/pkcvt_lead.sv
module pkcvt_lead #(
  parameter int W = 32,
  localparam int POS_W = $clog2(W)
) (
  input  logic [W-1:0]     vec,
  output logic [POS_W-1:0] pos,
  output logic             found
);
  // Scan upward; the highest set bit is the last one written.
  always_comb begin
    pos = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) pos = POS_W'(i);
    end
  end

  assign found = |vec;
endmodule

// File: rtl/pkcvt_lane.sv
module pkcvt_lane
  import pkcvt_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  logic [INT_W-1:0] ival,
  output dbl_t             dval
);
  localparam int POS_W = $clog2(INT_W);
  localparam int PAD   = FRAC_W - (INT_W - 1);

  logic             neg;
  logic [INT_W-1:0] mag;
  logic [POS_W-1:0] lead_pos;
  logic             nonzero;
  logic [POS_W-1:0] shamt;
  logic [INT_W-1:0] norm;
  logic [FRAC_W-1:0] frac_w;

  assign neg = ival[INT_W-1];
  // Two's complement magnitude; the most negative value maps to 2^(INT_W-1).
  assign mag = neg ? (~ival + INT_W'(1)) : ival;

  pkcvt_lead #(.W(INT_W)) u_lead (
    .vec   (mag),
    .pos   (lead_pos),
    .found (nonzero)
  );

  assign shamt = POS_W'(INT_W - 1) - lead_pos;
  assign norm  = mag << shamt;

  // Bits below the hidden one go to the top of the fraction.
  generate
    if (PAD > 0) begin : g_pad
      assign frac_w = {norm[INT_W-2:0], {PAD{1'b0}}};
    end else begin : g_nopad
      assign frac_w = norm[INT_W-2:0];
    end
  endgenerate

  always_comb begin
    if (nonzero) begin
      dval.sign = neg;
      dval.expo = EXP_W'(EXP_BIAS) + EXP_W'(lead_pos);
      dval.frac = frac_w;
    end else begin
      dval = '0;
    end
  end
endmodule

// File: rtl/pkcvt_fpstate.sv
module pkcvt_fpstate #(
  parameter int NREG = 8,
  parameter int TAGB = 2,
  localparam int TOP_W = $clog2(NREG),
  localparam int TAG_W = NREG * TAGB
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_en,
  input  logic             ld_en,
  input  logic [TOP_W-1:0] ld_top,
  input  logic [TAG_W-1:0] ld_tag,
  output logic [TOP_W-1:0] top,
  output logic [TAG_W-1:0] tag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      top <= '0;
      tag <= '1;
    end else if (clr_en) begin
      top <= '0;
      tag <= '0;
    end else if (ld_en) begin
      top <= ld_top;
      tag <= ld_tag;
    end
  end
endmodule

// File: rtl/pkcvt_unit.sv
module pkcvt_unit
  import pkcvt_pkg::*;
#(
  parameter int LANES = 2,
  parameter int INT_W = 32,
  parameter int NREG  = 8,
  parameter int TAGB  = 2,
  localparam int SRC_W = LANES * INT_W,
  localparam int RES_W = LANES * DBL_W,
  localparam int TOP_W = $clog2(NREG),
  localparam int TAG_W = NREG * TAGB
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SRC_W-1:0] in_src,
  input  logic             in_from_reg,
  input  logic             fp_exc_pending,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [RES_W-1:0] out_result,
  output logic             out_exc,
  input  logic             st_wr_en,
  input  logic [TOP_W-1:0] st_wr_top,
  input  logic [TAG_W-1:0] st_wr_tag,
  output logic [TOP_W-1:0] stk_top,
  output logic [TAG_W-1:0] tag_word
);
  logic [RES_W-1:0] conv_flat;
  logic             accept;
  logic             defer;
  logic             clear_state;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      dbl_t lane_out;
      pkcvt_lane #(.INT_W(INT_W)) u_lane (
        .ival (in_src[g*INT_W +: INT_W]),
        .dval (lane_out)
      );
      assign conv_flat[g*DBL_W +: DBL_W] = lane_out;
    end
  endgenerate

  assign in_ready    = ~out_valid | out_ready;
  assign accept      = in_valid & in_ready;
  assign defer       = in_from_reg & fp_exc_pending;
  assign clear_state = accept & in_from_reg & ~fp_exc_pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_exc    <= 1'b0;
      out_result <= '0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_exc    <= defer;
      out_result <= defer ? '0 : conv_flat;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  pkcvt_fpstate #(.NREG(NREG), .TAGB(TAGB)) u_state (
    .clk    (clk),
    .rst    (rst),
    .clr_en (clear_state),
    .ld_en  (st_wr_en),
    .ld_top (st_wr_top),
    .ld_tag (st_wr_tag),
    .top    (stk_top),
    .tag    (tag_word)
  );
endmodule

// File: rtl/pkcvt_unit_chk.sv
module pkcvt_unit_chk #(
  parameter int SRC_W = 64,
  parameter int RES_W = 128,
  parameter int TOP_W = 3,
  parameter int TAG_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [SRC_W-1:0] in_src,
  input logic             in_from_reg,
  input logic             fp_exc_pending,
  input logic             out_valid,
  input logic             out_ready,
  input logic [RES_W-1:0] out_result,
  input logic             out_exc,
  input logic             st_wr_en,
  input logic [TOP_W-1:0] st_wr_top,
  input logic [TAG_W-1:0] st_wr_tag,
  input logic [TOP_W-1:0] stk_top,
  input logic [TAG_W-1:0] tag_word
);
  logic acc;
  assign acc = in_valid && in_ready;

  assert_reset_R8: assert property (@(posedge clk)
    rst |=> !out_valid && stk_top == '0 && tag_word == '1);

  assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
    acc |=> out_valid);

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_exc));

  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    acc && in_from_reg && !fp_exc_pending |=> stk_top == '0 && tag_word == '0);

  assert_mem_keep_R6: assert property (@(posedge clk) disable iff (rst)
    acc && !in_from_reg && !st_wr_en |=> $stable(stk_top) && $stable(tag_word) && !out_exc);

  assert_defer_R7: assert property (@(posedge clk) disable iff (rst)
    acc && in_from_reg && fp_exc_pending && !st_wr_en
      |=> out_exc && out_result == '0 && $stable(stk_top) && $stable(tag_word));

  assert_load_R9: assert property (@(posedge clk) disable iff (rst)
    st_wr_en && !(acc && in_from_reg && !fp_exc_pending)
      |=> stk_top == $past(st_wr_top) && tag_word == $past(st_wr_tag));

  assert_zero_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_exc && out_result[62:52] == 11'd0 |-> out_result[63:0] == 64'd0);
endmodule

bind pkcvt_unit pkcvt_unit_chk #(
  .SRC_W(SRC_W), .RES_W(RES_W), .TOP_W(TOP_W), .TAG_W(TAG_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_src(in_src), .in_from_reg(in_from_reg), .fp_exc_pending(fp_exc_pending),
  .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
  .out_exc(out_exc), .st_wr_en(st_wr_en), .st_wr_top(st_wr_top),
  .st_wr_tag(st_wr_tag), .stk_top(stk_top), .tag_word(tag_word)
);

// File: tb/pkcvt_unit_tb.sv
module pkcvt_unit_tb;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid, in_ready, in_from_reg, fp_exc_pending;
  logic [63:0]  in_src;
  logic         out_valid, out_ready, out_exc;
  logic [127:0] out_result;
  logic         st_wr_en;
  logic [2:0]   st_wr_top, stk_top;
  logic [15:0]  st_wr_tag, tag_word;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pkcvt_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_src(in_src), .in_from_reg(in_from_reg), .fp_exc_pending(fp_exc_pending),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_exc(out_exc), .st_wr_en(st_wr_en), .st_wr_top(st_wr_top),
    .st_wr_tag(st_wr_tag), .stk_top(stk_top), .tag_word(tag_word)
  );

  function automatic logic [63:0] ref_dbl(input int v);
    return $realtobits($itor(v));
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One operation with out_ready high; outputs sampled at the next falling edge.
  task automatic run_op(input int a, input int b, input logic fr, input logic pend,
                        input logic [2:0] exp_top, input logic [15:0] exp_tag, input string req);
    @(negedge clk);
    in_src = {b[31:0], a[31:0]};
    in_from_reg = fr;
    fp_exc_pending = pend;
    in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    chk({req, " out_valid"}, {127'd0, out_valid}, 128'd1);
    if (fr && pend) begin
      chk({req, " R7 exc beat"}, {out_exc, out_result[126:0]}, {1'b1, 127'd0});
    end else begin
      chk({req, " R1 lanes"}, out_result, {ref_dbl(b), ref_dbl(a)});
      chk({req, " exc flag"}, {127'd0, out_exc}, 128'd0);
    end
    chk({req, " state"}, {109'd0, stk_top, tag_word}, {109'd0, exp_top, exp_tag});
  endtask

  task automatic load_state(input logic [2:0] t, input logic [15:0] g);
    @(negedge clk);
    st_wr_en = 1'b1; st_wr_top = t; st_wr_tag = g;
    @(posedge clk);
    #1 st_wr_en = 1'b0;
    @(negedge clk);
    chk("R9 load", {109'd0, stk_top, tag_word}, {109'd0, t, g});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    rst = 1'b1; in_valid = 1'b0; in_src = '0; in_from_reg = 1'b0;
    fp_exc_pending = 1'b0; out_ready = 1'b1;
    st_wr_en = 1'b0; st_wr_top = '0; st_wr_tag = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R8 reset", {110'd0, out_valid, in_ready, stk_top, tag_word},
        {110'd0, 1'b0, 1'b1, 3'd0, 16'hFFFF});

    // R2 zero, R3 sign and most negative value
    run_op(0, 0, 1'b0, 1'b0, 3'd0, 16'hFFFF, "R2 zero");
    run_op(int'(32'h8000_0000), -1, 1'b0, 1'b0, 3'd0, 16'hFFFF, "R3 minint");
    chk("R3 minint literal", {64'd0, out_result[63:0]}, {64'd0, 64'hC1E0_0000_0000_0000});

    // R1: every leading-one position, both signs, memory source
    for (int k = 0; k < 31; k++) begin
      run_op(1 << k, -(1 << k), 1'b0, 1'b0, 3'd0, 16'hFFFF, "R1 pow2");
      run_op((1 << (k + 1)) - 1, -((1 << (k + 1)) - 1), 1'b0, 1'b0, 3'd0, 16'hFFFF, "R1 ones");
    end
    for (int v = -150; v <= 150; v++) begin
      run_op(v, -v * 3 + 7, 1'b0, 1'b1, 3'd0, 16'hFFFF, "R6 small range pend ignored");
    end
    lf = 32'hACE1_2357;
    for (int n = 0; n < 400; n++) begin
      int a;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      a = int'(lf);
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      run_op(a, int'(lf), 1'b0, 1'b0, 3'd0, 16'hFFFF, "R1 random");
    end

    // Stack-state side effects
    load_state(3'd5, 16'hA5C3);
    run_op(12345, -678, 1'b0, 1'b1, 3'd5, 16'hA5C3, "R6 memory keeps state");
    run_op(42, -42, 1'b1, 1'b1, 3'd5, 16'hA5C3, "R7 deferred");
    run_op(42, -42, 1'b1, 1'b0, 3'd0, 16'h0000, "R5 register clears");

    // R9 priority: clear beats load on the same edge
    load_state(3'd6, 16'h1234);
    @(negedge clk);
    st_wr_en = 1'b1; st_wr_top = 3'd3; st_wr_tag = 16'hBEEF;
    in_src = 64'd9; in_from_reg = 1'b1; fp_exc_pending = 1'b0; in_valid = 1'b1;
    @(posedge clk);
    #1 st_wr_en = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    chk("R9 clear wins", {109'd0, stk_top, tag_word}, 128'd0);
    // load beats a memory operation
    @(negedge clk);
    st_wr_en = 1'b1; st_wr_top = 3'd7; st_wr_tag = 16'h5A5A;
    in_from_reg = 1'b0; in_valid = 1'b1;
    @(posedge clk);
    #1 st_wr_en = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    chk("R9 load with memory op", {109'd0, stk_top, tag_word}, {109'd0, 3'd7, 16'h5A5A});

    // R4 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_src = {32'd2, 32'd1}; in_from_reg = 1'b0; in_valid = 1'b1;
    @(posedge clk);
    #1 in_src = {32'd4, 32'd3};
    @(negedge clk);
    chk("R4 first beat", out_result, {ref_dbl(2), ref_dbl(1)});
    chk("R4 in_ready low", {127'd0, in_ready}, 128'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R4 held", {out_valid, out_result[126:0]}, {1'b1, ref_dbl(2)}[127:0] == 0 ? 128'd0 : {1'b1, out_result[126:0]});
    chk("R4 held data", out_result, {ref_dbl(2), ref_dbl(1)});
    out_ready = 1'b1;
    #0 chk("R4 in_ready follows out_ready", {127'd0, in_ready}, 128'd1);
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    chk("R4 second beat", {127'd0, out_valid}, 128'd1);
    chk("R4 second data", out_result, {ref_dbl(4), ref_dbl(3)});
    @(negedge clk);
    chk("R4 drained", {127'd0, out_valid}, 128'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule